// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides a 2N-bit unsigned dividend by an N-bit unsigned divisor over several clock cycles. It returns an N-bit quotient and an N-bit remainder such that dividend = divisor × quotient + remainder. A single (N+1)-bit partial remainder register, whose top bit is a sign bit, sits above an N-bit register. The N-bit register starts out holding the low dividend bits and fills up with quotient bits as they are produced. One adder/subtractor is reused on every step. The sign of the partial remainder from the previous step chooses whether that step adds or subtracts the divisor, so no step ever has to restore an old value. The very first step always subtracts, because the starting partial remainder is non-negative. After the last step, one correction cycle adds the divisor back if the final partial remainder is negative.

A client pulses `start_i` with the operands. It then waits for the one-cycle `done_o` pulse and reads the results, which stay in place until the next completion. The controller is a four-state machine with these states and transitions:
- IDLE → CALC on an accepted start with a non-zero divisor, or IDLE → FIX on an accepted start with a zero divisor.
- CALC stays in CALC for N steps, then moves CALC → FIX.
- FIX → DONE always. FIX latches the results.
- DONE → CALC or DONE → FIX on a new accepted start. Otherwise DONE → IDLE.

A start is accepted only in IDLE or DONE.

Top module: `nrdiv_seq`

## Requirements
- R1: When the high N dividend bits are below the divisor, the outputs satisfy dividend = divisor × quotient + remainder, with 0 ≤ remainder < divisor.
- R2: If a start with a non-zero divisor is accepted at rising edge k, `done_o` is high in the cycle that follows edge k+N+1.
- R3: `busy_o` is high from the edge that accepts a start until `done_o` rises, and `busy_o` and `done_o` are never high together.
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: `start_i` asserted while `busy_o` is high is ignored. The running division keeps its operands and its timing.
- R6: `quotient_o`, `remainder_o` and `div_zero_o` change only in the cycle in which `done_o` is high, and otherwise hold their values.
- R7: A zero divisor completes with `done_o` in the cycle that follows edge k+1. In that case `div_zero_o` = 1, the quotient is all ones, and the remainder equals the low N dividend bits. A non-zero divisor clears `div_zero_o` at completion.
- R8: After reset, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all 0.
- R9: A start is accepted in the cycle in which `done_o` is high, which allows back-to-back divisions.
- R10: For N=4, dividing 0111 by 0010 gives quotient 0011 and remainder 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a division, sampled at a rising edge |
| dividend_i | input | 2N | Unsigned dividend, sampled with start |
| divisor_i | input | N | Unsigned divisor, sampled with start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last completed division had a zero divisor |
| quotient_o | output | N | Quotient of the last completed division |
| remainder_o | output | N | Remainder of the last completed division |

## Verification
The in-RTL properties check on every cycle that:
- busy and done are exclusive and done lasts one cycle;
- a running division can only continue or complete;
- results never move outside a completion cycle;
- every completed in-range result satisfies the division identity with a remainder below the divisor, and zero-divisor results take their fixed pattern.

Only the bench's scenarios can show the exact latency from a start and the reset values. The same holds for a start raised mid-run being ignored, a start in the done cycle being taken, and the worked 7 ÷ 2 case. For N=4 the bench sweeps every in-range dividend/divisor pair and every dividend with a zero divisor.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_FIX,
        ST_DONE
    } nrdiv_state_e;

endpackage

// File: rtl/nrdiv_step.sv
// One non-restoring iteration: shift the {partial, low} pair left by one,
// add or subtract the divisor depending on the previous partial sign,
// and append the new quotient bit (1 when the new partial is non-negative).
module nrdiv_step #(
    parameter int N = 32
) (
    input  logic [N:0]   part_i,
    input  logic [N-1:0] low_i,
    input  logic [N-1:0] dvs_i,
    output logic [N:0]   part_o,
    output logic [N-1:0] low_o
);
    logic [N:0] shifted;
    logic [N:0] addend;
    logic [N:0] sum;

    always_comb begin
        shifted = {part_i[N-1:0], low_i[N-1]};
        addend  = {1'b0, dvs_i};
        // Modulo 2^(N+1): the true result lies in [-D, D) and so fits.
        if (part_i[N]) begin
            sum = shifted + addend;
        end else begin
            sum = shifted - addend;
        end
        part_o = sum;
        low_o  = {low_i[N-2:0], ~sum[N]};
    end
endmodule

// File: rtl/nrdiv_fix.sv
// Final correction: a negative partial remainder gets the divisor added once.
module nrdiv_fix #(
    parameter int N = 32
) (
    input  logic [N:0]   part_i,
    input  logic [N-1:0] dvs_i,
    output logic [N-1:0] rem_o
);
    logic [N-1:0] corrected;

    always_comb begin
        corrected = part_i[N-1:0] + dvs_i;
        rem_o     = part_i[N] ? corrected : part_i[N-1:0];
    end
endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq
    import nrdiv_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2*N-1:0] dividend_i,
    input  logic [N-1:0]   divisor_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           div_zero_o,
    output logic [N-1:0]   quotient_o,
    output logic [N-1:0]   remainder_o
);
    localparam int          CW   = $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    nrdiv_state_e state_q, state_nx;

    logic [N:0]     part_q;
    logic [N-1:0]   low_q;
    logic [N-1:0]   dvs_q;
    logic [CW-1:0]  cnt_q;
    logic           zero_q;
    logic [N-1:0]   quo_q;
    logic [N-1:0]   rem_q;
    logic           zflag_q;
    logic [2*N-1:0] dvd_q;
    logic           fits_q;

    logic [N:0]     step_part;
    logic [N-1:0]   step_low;
    logic [N-1:0]   fix_rem;
    logic           accept;

    nrdiv_step #(.N(N)) u_step (
        .part_i (part_q),
        .low_i  (low_q),
        .dvs_i  (dvs_q),
        .part_o (step_part),
        .low_o  (step_low)
    );

    nrdiv_fix #(.N(N)) u_fix (
        .part_i (part_q),
        .dvs_i  (dvs_q),
        .rem_o  (fix_rem)
    );

    assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_nx = (divisor_i == '0) ? ST_FIX : ST_CALC;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_CALC: begin
                if (cnt_q == LAST) begin
                    state_nx = ST_FIX;
                end
            end
            ST_FIX: begin
                state_nx = ST_DONE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // Datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q  <= '0;
            low_q   <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            zero_q  <= 1'b0;
            quo_q   <= '0;
            rem_q   <= '0;
            zflag_q <= 1'b0;
            dvd_q   <= '0;
            fits_q  <= 1'b0;
        end else begin
            if (accept) begin
                part_q <= {1'b0, dividend_i[2*N-1:N]};
                low_q  <= dividend_i[N-1:0];
                dvs_q  <= divisor_i;
                cnt_q  <= '0;
                zero_q <= (divisor_i == '0);
                dvd_q  <= dividend_i;
                fits_q <= (dividend_i[2*N-1:N] < divisor_i);
            end else if (state_q == ST_CALC) begin
                part_q <= step_part;
                low_q  <= step_low;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (state_q == ST_FIX) begin
                quo_q   <= zero_q ? '1 : low_q;
                rem_q   <= zero_q ? low_q : fix_rem;
                zflag_q <= zero_q;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q == ST_CALC) || (state_q == ST_FIX);
        done_o      = (state_q == ST_DONE);
        div_zero_o  = zflag_q;
        quotient_o  = quo_q;
        remainder_o = rem_q;
    end

    // R3: busy and done never overlap
    a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R3: a running division either continues or completes
    a_r3_busy_runs: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    // R4: done is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: results move only with the done pulse
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done_o || ($stable(quotient_o) && $stable(remainder_o)
                             && $stable(div_zero_o))));

    // R1: division identity and remainder range for in-range operands
    a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o && fits_q) |->
            (remainder_o < dvs_q) &&
            (({{N{1'b0}}, quotient_o} * {{N{1'b0}}, dvs_q}
              + {{N{1'b0}}, remainder_o}) == dvd_q));

    // R7: zero-divisor result pattern
    a_r7_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |->
            ((&quotient_o) && (remainder_o == dvd_q[N-1:0])));
endmodule

// File: tb/nrdiv_seq_tb.sv
module nrdiv_seq_tb;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [2*N-1:0] dividend_i = '0;
    logic [N-1:0]   divisor_i = '0;
    logic           busy_o, done_o, div_zero_o;
    logic [N-1:0]   quotient_o, remainder_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nrdiv_seq #(.N(N)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .div_zero_o  (div_zero_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive a start at a negedge, wait for done; ends at the negedge where done is seen.
    task automatic run_div(input int dvd, input int dvs, input string req);
        int cyc;
        int expq, expr, expz, expl;
        dividend_i = (2*N)'(dvd);
        divisor_i  = N'(dvs);
        start_i    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R3", "busy after start", int'(busy_o), 1);
        cyc = 1;
        while (!done_o && cyc < 100) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        if (dvs == 0) begin
            expq = (1 << N) - 1; expr = dvd % (1 << N); expz = 1; expl = 2;
        end else begin
            expq = dvd / dvs; expr = dvd % dvs; expz = 0; expl = N + 2;
        end
        // cyc counts negedges from start edge to done visibility
        check(dvs == 0 ? "R7" : "R2", "latency", cyc, expl);
        check(dvs == 0 ? "R7" : req, "quotient", int'(quotient_o), expq);
        check(dvs == 0 ? "R7" : req, "remainder", int'(remainder_o), expr);
        check("R7", "div_zero flag", int'(div_zero_o), expz);
        check("R3", "busy low at done", int'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0] hq, hr;
        repeat (3) @(negedge clk);
        // R8: reset values
        check("R8", "busy", int'(busy_o), 0);
        check("R8", "done", int'(done_o), 0);
        check("R8", "div_zero", int'(div_zero_o), 0);
        check("R8", "quotient", int'(quotient_o), 0);
        check("R8", "remainder", int'(remainder_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: worked example 7 / 2
        run_div(7, 2, "R10");

        // R4: done lasts one cycle; R6: results hold afterwards
        hq = quotient_o; hr = remainder_o;
        @(posedge clk); @(negedge clk);
        check("R4", "done after pulse", int'(done_o), 0);
        repeat (5) @(negedge clk);
        check("R6", "held quotient", int'(quotient_o), int'(hq));
        check("R6", "held remainder", int'(remainder_o), int'(hr));

        // R5: start during busy is ignored
        dividend_i = 8'h5B; divisor_i = 4'd9; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        dividend_i = 8'hFF; divisor_i = 4'd1; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        begin
            int cyc = 3;
            while (!done_o && cyc < 100) begin
                @(posedge clk); @(negedge clk);
                cyc++;
            end
            check("R5", "latency kept", cyc, N + 2);
            check("R5", "quotient of first op", int'(quotient_o), 91 / 9);
            check("R5", "remainder of first op", int'(remainder_o), 91 % 9);
        end
        @(posedge clk); @(negedge clk);

        // R1/R9: exhaustive in-range sweep, each start issued in the done cycle
        for (int dv = 1; dv < (1 << N); dv++) begin
            for (int hi = 0; hi < dv; hi++) begin
                for (int lo = 0; lo < (1 << N); lo++) begin
                    run_div(hi * (1 << N) + lo, dv, "R1");
                end
            end
        end
        run_div(200, 15, "R9");

        // R7: zero divisor over every dividend
        for (int d = 0; d < (1 << (2*N)); d++) begin
            run_div(d, 0, "R7");
        end
        // R7: flag clears on a normal completion
        run_div(9, 3, "R1");

        @(posedge clk); @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule